// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. A parallel request names one of seven operations, an address, a write word and a burst length. The block turns it into a framed serial transaction on chip select, serial clock and data-to-device, and it samples the data-from-device line. Each frame begins with a start bit. A two-bit opcode follows, and then the address with its most significant bit first. Operations that hold no address put a selector code in the top two address bits.

Reads discard the leading dummy zero that the device emits. A burst then streams further words while chip select stays high, and the command is not sent again. After a programming operation the block keeps chip select high with the clock parked. It watches the ready/busy level that the device returns, so completion follows the device's real programming time and no fixed wait is used. A timeout guards that wait. Chip select is held low for a minimum time between commands. The serial clock half-period is set by a parameter, in system clocks.

Top module: `uwire_eeprom_host`

## Requirements
- R1: Reset state: `cs_o`, `sclk_o`, `di_o`, `busy_o`, `done_o`, `rvalid_o` and `timeout_o` are all 0.
- R2: The frame is a start bit of 1, then the opcode, then the ADDR_W address bits, all MSB first. `di_o` changes only while `sclk_o` is low, and the device samples it on the rising edge. cmd_i codes and the opcodes they send: 0 read = `10`, 1 write = `01`, 2 erase = `11`. Codes 3 to 6 send opcode `00` with a selector in address bits [ADDR_W-1:ADDR_W-2] and zeros below it: 3 erase-all = `10`, 4 write-all = `01`, 5 write-enable = `11`, 6 write-disable = `00`.
- R3: `sclk_o` idles low and pulses only while `cs_o` is high. Each high phase lasts exactly DIV system clocks.
- R4: On a read, the bit sampled on the falling edge right after the last address bit is discarded. The next DATA_W falling-edge samples form the word, MSB first. `rdata_o` is presented with a one-cycle `rvalid_o` pulse.
- R5: A read with `burst_i` = N returns N consecutive words from a single frame header, and `burst_i` = 0 counts as 1. Chip select stays high for the whole burst.
- R6: Write and write-all shift the DATA_W-bit `wdata_i` after the address field, MSB first.
- R7: After write, erase, erase-all or write-all, `cs_o` stays high with `sclk_o` low until `do_i` reads 1. Only then does `cs_o` drop, and never earlier.
- R8: If `do_i` does not read 1 within TMO_CYC cycles of polling, `timeout_o` is set, `cs_o` drops and the command completes. `timeout_o` holds until the next accepted request.
- R9: `busy_o` is high from the accepted request until a one-cycle `done_o` pulse, which coincides with `busy_o` falling. `cs_o` stays low for at least 2*DIV cycles between commands.
- R10: `start_i` is ignored while `busy_o` is high, and also when `cmd_i` = 7.
- R11: Write-enable and write-disable complete without polling the ready/busy level, whatever `do_i` shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| cmd_i | input | 3 | Operation code (see R2) |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Word for write / write-all |
| burst_i | input | BURST_W | Words to read (0 means 1) |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last programming poll timed out |
| rdata_o | output | DATA_W | Read word |
| rvalid_o | output | 1 | Read word strobe |
| cs_o | output | 1 | Device chip select |
| sclk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial data to device |
| do_i | input | 1 | Serial data / ready-busy from device |

## Verification
The bench attaches a behavioural device model and checks expected words through a scoreboard. A design that kept the dummy zero would return every word shifted right by one bit. A design that re-sent the header in a burst would be caught by the model's frame count. The bench stretches the device busy time so that a controller finishing after a fixed delay drops chip select too early, and it makes the device never become ready so that a missing timeout hangs or leaves the flag clear. It also marks the device busy just before write-enable to catch a controller that polls on non-programming commands. It issues requests while busy and with the reserved code to check that both are ignored.

// File: rtl/uwh_pkg.sv
package uwh_pkg;
  typedef enum logic [2:0] {
    CMD_READ  = 3'd0,
    CMD_WRITE = 3'd1,
    CMD_ERASE = 3'd2,
    CMD_ERAL  = 3'd3,
    CMD_WRAL  = 3'd4,
    CMD_EWEN  = 3'd5,
    CMD_EWDS  = 3'd6
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CLK,
    ST_POLL,
    ST_GAP
  } state_e;
endpackage

// File: rtl/uwh_tick_gen.sv
module uwh_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R3
endmodule

// File: rtl/uwh_poll_timer.sv
module uwh_poll_timer #(
  parameter int TMO_CYC = 300
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  AST_TMR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R8
endmodule

// File: rtl/uwh_rx_word.sv
module uwh_rx_word #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              smp_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [DATA_W-1:0] sr_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clr_i) begin
        cnt_q <= '0;
      end else if (smp_i) begin
        sr_q <= {sr_q[DATA_W-2:0], bit_i};
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          word_o  <= {sr_q[DATA_W-2:0], bit_i};
          valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_RX_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R4
endmodule

// File: rtl/uwire_eeprom_host.sv
module uwire_eeprom_host
  import uwh_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16,
  parameter int BURST_W = 3,
  parameter int DIV     = 4,
  parameter int TMO_CYC = 300
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [2:0]         cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [BURST_W-1:0] burst_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               timeout_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o,
  output logic               cs_o,
  output logic               sclk_o,
  output logic               di_o,
  input  logic               do_i
);
  localparam int HDR_W     = 3 + ADDR_W;
  localparam int TX_W      = HDR_W + DATA_W;
  localparam int MAX_WORDS = (1 << BURST_W) - 1;
  localparam int MAX_CYC   = HDR_W + MAX_WORDS * DATA_W;
  localparam int CYC_W     = $clog2(MAX_CYC + 1);

  state_e          state_q;
  logic            sclk_q, cs_q, di_q, done_q, tmo_q, gap_q;
  logic            is_rd_q, is_prog_q;
  logic [TX_W-1:0] tx_sr_q;
  logic [CYC_W-1:0] cyc_q, n_tx_q, n_tot_q, cyc_nx;
  logic [1:0]      do_sync_q;
  logic            do_s, tick, expired, accept, smp;

  // Request decode
  logic [1:0]        opc;
  logic [ADDR_W-1:0] afld;
  logic              has_data, prog, rd;
  logic [CYC_W-1:0]  n_tx_c, n_tot_c;
  int                words;

  always_comb begin
    opc      = 2'b00;
    afld     = '0;
    has_data = 1'b0;
    prog     = 1'b0;
    rd       = 1'b0;
    unique case (cmd_e'(cmd_i))
      CMD_READ:  begin opc = 2'b10; afld = addr_i; rd = 1'b1; end
      CMD_WRITE: begin opc = 2'b01; afld = addr_i; has_data = 1'b1; prog = 1'b1; end
      CMD_ERASE: begin opc = 2'b11; afld = addr_i; prog = 1'b1; end
      CMD_ERAL:  begin afld[ADDR_W-1 -: 2] = 2'b10; prog = 1'b1; end
      CMD_WRAL:  begin afld[ADDR_W-1 -: 2] = 2'b01; has_data = 1'b1; prog = 1'b1; end
      CMD_EWEN:  afld[ADDR_W-1 -: 2] = 2'b11;
      default:   afld[ADDR_W-1 -: 2] = 2'b00;
    endcase
    words   = (burst_i == '0) ? 1 : int'(burst_i);
    n_tx_c  = has_data ? CYC_W'(TX_W) : CYC_W'(HDR_W);
    n_tot_c = rd ? CYC_W'(HDR_W + words * DATA_W) : n_tx_c;
  end

  assign accept = start_i && (state_q == ST_IDLE) && (cmd_i != 3'd7);
  assign cyc_nx = cyc_q + 1'b1;
  assign do_s   = do_sync_q[1];

  uwh_tick_gen #(.DIV(DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_SETUP || state_q == ST_CLK || state_q == ST_GAP),
    .tick_o (tick)
  );

  uwh_poll_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_POLL),
    .expired_o (expired)
  );

  // Sample on falling edges after the dummy bit
  assign smp = (state_q == ST_CLK) && tick && sclk_q && is_rd_q && (cyc_q >= n_tx_q);

  uwh_rx_word #(.DATA_W(DATA_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .smp_i   (smp),
    .bit_i   (do_s),
    .word_o  (rdata_o),
    .valid_o (rvalid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) do_sync_q <= '0;
    else         do_sync_q <= {do_sync_q[0], do_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sclk_q    <= 1'b0;
      cs_q      <= 1'b0;
      di_q      <= 1'b0;
      done_q    <= 1'b0;
      tmo_q     <= 1'b0;
      gap_q     <= 1'b0;
      is_rd_q   <= 1'b0;
      is_prog_q <= 1'b0;
      tx_sr_q   <= '0;
      cyc_q     <= '0;
      n_tx_q    <= '0;
      n_tot_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q   <= ST_SETUP;
          cs_q      <= 1'b1;
          di_q      <= 1'b1;
          tmo_q     <= 1'b0;
          tx_sr_q   <= {1'b1, opc, afld, has_data ? wdata_i : {DATA_W{1'b0}}};
          n_tx_q    <= n_tx_c;
          n_tot_q   <= n_tot_c;
          is_rd_q   <= rd;
          is_prog_q <= prog;
          cyc_q     <= '0;
        end
        ST_SETUP: if (tick) state_q <= ST_CLK;
        ST_CLK: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q  <= 1'b0;
            cyc_q   <= cyc_nx;
            tx_sr_q <= tx_sr_q << 1;
            di_q    <= (cyc_nx < n_tx_q) ? tx_sr_q[TX_W-2] : 1'b0;
            if (cyc_nx == n_tot_q) begin
              if (is_prog_q) begin
                state_q <= ST_POLL;
              end else begin
                state_q <= ST_GAP;
                cs_q    <= 1'b0;
              end
            end
          end
        end
        ST_POLL: begin
          if (do_s) begin
            cs_q    <= 1'b0;
            state_q <= ST_GAP;
          end else if (expired) begin
            tmo_q   <= 1'b1;
            cs_q    <= 1'b0;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: if (tick) begin
          if (gap_q) begin
            gap_q   <= 1'b0;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            gap_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = tmo_q;
  assign cs_o      = cs_q;
  assign sclk_o    = sclk_q;
  assign di_o      = di_q;

  AST_SCLK_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> cs_o); // R3
  AST_DI_HOLD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(di_o)); // R2
  AST_POLL_PARKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL) |-> (cs_o && !sclk_o)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !cs_o)); // R9
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |=> !cs_o); // R9
  AST_RVALID_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> busy_o); // R4
endmodule

// File: tb/uwire_eeprom_host_tb_top.sv
module uwire_eeprom_host_tb_top;
  localparam int ADDR_W = 6, DATA_W = 16, BURST_W = 3, DIV = 4, TMO_CYC = 300;
  localparam logic [2:0] C_RD = 3'd0, C_WR = 3'd1, C_ER = 3'd2, C_ERAL = 3'd3,
                         C_WRAL = 3'd4, C_EWEN = 3'd5, C_EWDS = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] cmd = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [BURST_W-1:0] burst = '0;
  logic busy_o, done_o, timeout_o, rvalid_o, cs_o, sclk_o, di_o, do_w;
  logic [DATA_W-1:0] rdata_o;

  always #2.5 clk = ~clk;

  uwire_eeprom_host #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BURST_W(BURST_W),
                      .DIV(DIV), .TMO_CYC(TMO_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .addr_i(addr),
    .wdata_i(wdata), .burst_i(burst), .busy_o(busy_o), .done_o(done_o),
    .timeout_o(timeout_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o), .cs_o(cs_o),
    .sclk_o(sclk_o), .di_o(di_o), .do_i(do_w));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Device model
  int cyc_no = 0, busy_until = 0, busy_len = 60, cs_fall_cyc = 0;
  always @(posedge clk) cyc_no <= cyc_no + 1;
  always @(negedge cs_o) cs_fall_cyc = cyc_no;

  logic [DATA_W-1:0] m_mem [64];
  logic m_we = 1'b0, m_started = 1'b0, m_rd = 1'b0, m_do = 1'b0;
  int m_cnt = 0, m_oidx = 0, m_frames = 0;
  logic [31:0] m_sr = '0;
  logic [5:0] m_addr = '0;
  logic [DATA_W-1:0] m_word = '0;
  logic [1:0] frm_op = '0;
  logic [5:0] frm_addr = '0;
  logic [15:0] frm_data = '0;

  assign do_w = cs_o & (cyc_no >= busy_until) & m_do;

  task automatic m_prog();
    if (m_we) busy_until = cyc_no + busy_len;
    m_do = 1'b1;
  endtask

  always @(posedge sclk_o or negedge cs_o) begin
    if (!cs_o) begin
      m_started = 0; m_cnt = 0; m_rd = 0; m_do = 0;
    end else if (m_rd) begin
      m_do = m_word[15-m_oidx];
      m_oidx++;
      if (m_oidx == 16) begin
        m_oidx = 0; m_addr = m_addr + 1'b1; m_word = m_mem[m_addr];
      end
    end else if (!m_started) begin
      if (di_o) begin m_started = 1; m_cnt = 0; m_frames++; end
    end else begin
      m_sr = {m_sr[30:0], di_o};
      m_cnt++;
      if (m_cnt == 8) begin
        frm_op = m_sr[7:6]; frm_addr = m_sr[5:0];
        case (frm_op)
          2'b10: begin m_rd = 1; m_do = 0; m_addr = frm_addr; m_word = m_mem[m_addr]; m_oidx = 0; end
          2'b11: begin if (m_we) m_mem[frm_addr] = 16'hFFFF; m_prog(); end
          2'b00: case (frm_addr[5:4])
                   2'b11: m_we = 1;
                   2'b00: m_we = 0;
                   2'b10: begin if (m_we) for (int i = 0; i < 64; i++) m_mem[i] = 16'hFFFF; m_prog(); end
                   default: ;
                 endcase
          default: ;
        endcase
      end else if (m_cnt == 24) begin
        frm_data = m_sr[15:0];
        if (frm_op == 2'b01) begin
          if (m_we) m_mem[frm_addr] = frm_data;
          m_prog();
        end else if (frm_op == 2'b00 && frm_addr[5:4] == 2'b01) begin
          if (m_we) for (int i = 0; i < 64; i++) m_mem[i] = frm_data;
          m_prog();
        end
      end
    end
  end

  // Scoreboard
  logic [DATA_W-1:0] exp_mem [64];
  logic [DATA_W-1:0] sb_q[$];
  int rv_cnt = 0;
  always @(negedge clk) if (rst_n && rvalid_o) begin
    rv_cnt++;
    if (sb_q.size() == 0) chk("R4 unexpected word", 32'(rdata_o), 32'hDEAD);
    else chk("R4/R5 read word", 32'(rdata_o), 32'(sb_q.pop_front()));
  end

  // Timing monitors
  int hi_cnt = 0, lo_cnt = 0, sclk_bad = 0, gap_bad = 0;
  bit seen_hi = 0;
  always @(negedge clk) if (rst_n) begin
    if (sclk_o) hi_cnt++;
    else begin
      if (hi_cnt != 0 && hi_cnt != DIV) sclk_bad++;
      hi_cnt = 0;
    end
    if (!cs_o) lo_cnt++;
    else begin
      if (seen_hi && lo_cnt != 0 && lo_cnt < 2 * DIV) gap_bad++;
      lo_cnt = 0; seen_hi = 1;
    end
  end

  task automatic run_cmd(input logic [2:0] c, input logic [5:0] a,
                         input logic [15:0] d, input logic [2:0] b);
    int n = 0;
    int w = (b == 0) ? 1 : int'(b);
    if (c == C_RD) for (int i = 0; i < w; i++) sb_q.push_back(exp_mem[6'(a + i)]);
    @(negedge clk); cmd = c; addr = a; wdata = d; burst = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 busy after accept", 32'(busy_o), 1);
    while (!done_o && n < 20000) begin @(negedge clk); n++; end
    chk("R9 done reached", 32'(n < 20000), 1);
    chk("R9 busy clear at done", 32'(busy_o), 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0, r0;
    for (int i = 0; i < 64; i++) begin m_mem[i] = '0; exp_mem[i] = '0; end
    repeat (3) @(negedge clk);
    chk("R1 cs", 32'(cs_o), 0); chk("R1 sclk", 32'(sclk_o), 0);
    chk("R1 di", 32'(di_o), 0); chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0); chk("R1 rvalid", 32'(rvalid_o), 0);
    chk("R1 timeout", 32'(timeout_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11: enable while device reports busy; must not poll
    busy_until = cyc_no + 5000;
    run_cmd(C_EWEN, 6'h00, 16'h0, 3'd0);
    chk("R11 no timeout on enable", 32'(timeout_o), 0);
    chk("R2 enable opcode", 32'(frm_op), 0);
    chk("R2 enable selector", 32'(frm_addr), 32'h30);
    busy_until = 0;

    // R6/R7 write
    run_cmd(C_WR, 6'd5, 16'hA5C3, 3'd0); exp_mem[5] = 16'hA5C3;
    chk("R2 write opcode", 32'(frm_op), 1);
    chk("R2 write addr", 32'(frm_addr), 5);
    chk("R6 write data", 32'(frm_data), 32'hA5C3);
    chk("R7 cs held until ready", 32'(cs_fall_cyc >= busy_until), 1);
    chk("R8 no timeout", 32'(timeout_o), 0);

    // R4 single read
    run_cmd(C_RD, 6'd5, 16'h0, 3'd1);

    // R5 burst
    run_cmd(C_WR, 6'd6, 16'h1111, 3'd0); exp_mem[6] = 16'h1111;
    run_cmd(C_WR, 6'd7, 16'h8001, 3'd0); exp_mem[7] = 16'h8001;
    run_cmd(C_WR, 6'd8, 16'h7FFE, 3'd0); exp_mem[8] = 16'h7FFE;
    f0 = m_frames;
    run_cmd(C_RD, 6'd5, 16'h0, 3'd4);
    chk("R5 one header per burst", 32'(m_frames - f0), 1);
    r0 = rv_cnt;
    run_cmd(C_RD, 6'd7, 16'h0, 3'd0);
    chk("R5 burst zero gives one word", 32'(rv_cnt - r0), 1);

    // erase
    run_cmd(C_ER, 6'd6, 16'h0, 3'd0); exp_mem[6] = 16'hFFFF;
    chk("R2 erase opcode", 32'(frm_op), 3);
    run_cmd(C_RD, 6'd6, 16'h0, 3'd1);

    // write-all
    run_cmd(C_WRAL, 6'd0, 16'h1234, 3'd0);
    for (int i = 0; i < 64; i++) exp_mem[i] = 16'h1234;
    chk("R2 write-all selector", 32'(frm_addr), 32'h10);
    chk("R6 write-all data", 32'(frm_data), 32'h1234);
    run_cmd(C_RD, 6'd0, 16'h0, 3'd7);

    // erase-all
    run_cmd(C_ERAL, 6'd0, 16'h0, 3'd0);
    for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
    chk("R2 erase-all selector", 32'(frm_addr), 32'h20);
    run_cmd(C_RD, 6'd62, 16'h0, 3'd2);

    // R10 start while busy
    f0 = m_frames;
    sb_q.push_back(exp_mem[3]); sb_q.push_back(exp_mem[4]); sb_q.push_back(exp_mem[5]);
    @(negedge clk); cmd = C_RD; addr = 6'd3; burst = 3'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    cmd = C_ER; addr = 6'd9; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (3 * DIV) @(negedge clk);
    chk("R10 busy start ignored (frames)", 32'(m_frames - f0), 1);
    chk("R10 busy start ignored (busy)", 32'(busy_o), 0);
    chk("R10 busy start ignored (op)", 32'(frm_op), 2);

    // R10 reserved code
    @(negedge clk); cmd = 3'd7; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 code 7 busy", 32'(busy_o), 0);
    chk("R10 code 7 cs", 32'(cs_o), 0);

    // disable
    run_cmd(C_EWDS, 6'd0, 16'h0, 3'd0);
    chk("R2 disable selector", 32'(frm_addr), 0);

    // R8 timeout
    run_cmd(C_EWEN, 6'd0, 16'h0, 3'd0);
    busy_len = 1000;
    run_cmd(C_WR, 6'd9, 16'h5A5A, 3'd0); exp_mem[9] = 16'h5A5A;
    chk("R8 timeout flag", 32'(timeout_o), 1);
    chk("R8 cs dropped", 32'(cs_o), 0);
    repeat (10) @(negedge clk);
    chk("R8 timeout held", 32'(timeout_o), 1);
    while (cyc_no < busy_until + 5) @(negedge clk);
    busy_len = 60;
    run_cmd(C_RD, 6'd9, 16'h0, 3'd1);
    chk("R8 timeout cleared by new request", 32'(timeout_o), 0);

    repeat (5) @(negedge clk);
    chk("R3 sclk high width", 32'(sclk_bad), 0);
    chk("R9 cs low gap", 32'(gap_bad), 0);
    chk("R4 scoreboard drained", 32'(sb_q.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule